// File: doc/BRIEF.md
# Tag Rule Cache

The tag rule cache decides, once per instruction, whether an operation may proceed and which tags its result and the program counter should carry. Programmable masks pick bits out of the two operand tags, the PC tag and the opcode; the picked fields are joined with the current principal into a 40-bit key. The key is folded by XOR into a 6-bit set index, and its full value is compared against the four ways of that set. A match returns a trap flag, a 5-bit trap vector, a result tag and a new PC tag one cycle after the request.

When no way matches, the block stalls and raises a single refill request that carries the full key. A policy table outside the block answers with a one-cycle response pulse. The block then installs the answer into the set's round-robin victim way and presents it on the result outputs in the following cycle. A flush input clears every valid bit in one cycle. This lets software switch to a new policy table without touching any entries one by one.

Top module: `tag_rule_cache`

## Requirements
- R1: After reset, lookupStall, hitValid and refillReq are low and no entry is valid, so the first lookup misses.
- R2: The key is {principal[39:32], opcode&maskOpc [31:24], pcTag&maskPc [23:16], tagA&maskA [15:8], tagB&maskB [7:0]}. Bits cleared by a mask do not affect whether a lookup hits.
- R3: Identical tags under a different principal form a different key and miss.
- R4: On a hit, hitValid is high in the cycle after lookupValid, with the stored trap, trapVec, resTag and newPcTag, and the block does not stall.
- R5: On a miss, in the cycle after lookupValid, lookupStall is high and refillReq is high for exactly one cycle, with refillKey equal to the R2 key.
- R6: lookupStall stays high and refillKey stays stable until refillValid. In the cycle after refillValid, hitValid is high with the response fields and lookupStall is low.
- R7: A refilled entry hits on a later identical lookup.
- R8: flush invalidates every entry in one cycle. A lookup in the same cycle as flush is treated as a miss.
- R9: The set index is the XOR of the key's 6-bit slices (key zero-extended to 42 bits). Each set has 4 ways, replaced in round-robin order, so a fifth key in one set evicts the oldest install.
- R10: lookupValid pulses while the block is stalled are ignored. They create no request, no result and no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lookupValid | input | 1 | One-cycle lookup request |
| tagA | input | 8 | First operand tag |
| tagB | input | 8 | Second operand tag |
| pcTag | input | 8 | Program counter tag |
| opcode | input | 8 | Instruction opcode |
| principal | input | 8 | Current principal |
| maskA | input | 8 | Field mask for tagA |
| maskB | input | 8 | Field mask for tagB |
| maskPc | input | 8 | Field mask for pcTag |
| maskOpc | input | 8 | Field mask for opcode |
| lookupStall | output | 1 | Miss pending |
| hitValid | output | 1 | Result outputs valid |
| trap | output | 1 | Operation must trap |
| trapVec | output | 5 | Trap handler index |
| resTag | output | 8 | Tag for the result |
| newPcTag | output | 8 | Updated PC tag |
| refillReq | output | 1 | One-cycle refill request |
| refillKey | output | 40 | Key being refilled |
| refillValid | input | 1 | Refill response pulse |
| refillTrap | input | 1 | Response trap flag |
| refillVec | input | 5 | Response trap vector |
| refillResTag | input | 8 | Response result tag |
| refillPcTag | input | 8 | Response PC tag |

## Verification
The checker watches the miss handshake on every cycle. It checks that a request lasts one cycle and falls inside a stall, that the stall holds with a steady key until the response, that the cycle after the response brings a result and releases the stall, and that every result follows a lookup or a response by one cycle. Whether a given key hits at all depends on masking, principal separation, the fold hash, round-robin eviction and flush. Those properties only show up through the bench's scenarios, which compare each result against a policy computed independently from the expected key.

// File: rtl/tag_rule_cache_pkg.sv
package tag_rule_cache_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;     // latch the missing key and its set
    logic loadHit;     // present the matching way on the outputs
    logic install;     // write the refill into the victim way
    logic loadRefill;  // present the refill on the outputs
    logic flushAll;    // clear every valid bit
  } ctlStrobes_t;
endpackage

// File: rtl/tag_rule_cache_ctrl.sv
module tag_rule_cache_ctrl
  import tag_rule_cache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lookupValid,
  input  logic        hitFound,
  input  logic        flush,
  input  logic        refillValid,
  output ctlStrobes_t strobes,
  output logic        lookupStall,
  output logic        refillReq
);
  typedef enum logic [0:0] {ST_IDLE, ST_WAIT} state_t;
  state_t state, stateNext;
  logic missNow;

  // a flush in the lookup cycle forces a miss
  assign missNow = (state == ST_IDLE) && lookupValid && (!hitFound || flush);

  always_comb begin
    strobes = '0;
    strobes.flushAll = flush;
    stateNext = state;
    case (state)
      ST_IDLE: if (lookupValid) begin
        if (hitFound && !flush) strobes.loadHit = 1'b1;
        else begin
          strobes.capture = 1'b1;
          stateNext = ST_WAIT;
        end
      end
      ST_WAIT: if (refillValid) begin
        strobes.loadRefill = 1'b1;
        strobes.install = !flush;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      refillReq <= 1'b0;
    end else begin
      state <= stateNext;
      refillReq <= missNow;
    end
  end

  assign lookupStall = (state == ST_WAIT);
endmodule

// File: rtl/tag_rule_cache_dp.sv
module tag_rule_cache_dp
  import tag_rule_cache_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int OPC_W  = 8,
  parameter int PRIN_W = 8,
  parameter int VEC_W  = 5,
  parameter int WAYS   = 4,
  parameter int SETS   = 64,
  localparam int KEY_W = 3 * TAG_W + OPC_W + PRIN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [TAG_W-1:0]  tagA,
  input  logic [TAG_W-1:0]  tagB,
  input  logic [TAG_W-1:0]  pcTag,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [PRIN_W-1:0] principal,
  input  logic [TAG_W-1:0]  maskA,
  input  logic [TAG_W-1:0]  maskB,
  input  logic [TAG_W-1:0]  maskPc,
  input  logic [OPC_W-1:0]  maskOpc,
  input  logic              refillTrap,
  input  logic [VEC_W-1:0]  refillVec,
  input  logic [TAG_W-1:0]  refillResTag,
  input  logic [TAG_W-1:0]  refillPcTag,
  output logic              hitFound,
  output logic              outValid,
  output logic              outTrap,
  output logic [VEC_W-1:0]  outVec,
  output logic [TAG_W-1:0]  outRes,
  output logic [TAG_W-1:0]  outPc,
  output logic [KEY_W-1:0]  pendKey
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int CHUNKS = (KEY_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = CHUNKS * IDX_W;

  logic [KEY_W-1:0] lookupKey;
  logic [PAD_W-1:0] padded;
  logic [IDX_W-1:0] setIdx, pendIdx;

  logic [KEY_W-1:0] keyMem  [SETS][WAYS];
  logic             trapMem [SETS][WAYS];
  logic [VEC_W-1:0] vecMem  [SETS][WAYS];
  logic [TAG_W-1:0] resMem  [SETS][WAYS];
  logic [TAG_W-1:0] pcMem   [SETS][WAYS];
  logic [WAYS-1:0]  validMem [SETS];
  logic [WAY_W-1:0] rrPtr    [SETS];

  logic [WAYS-1:0]  wayMatch;
  logic             hitTrap;
  logic [VEC_W-1:0] hitVec;
  logic [TAG_W-1:0] hitRes, hitPc;

  assign lookupKey = {principal, opcode & maskOpc, pcTag & maskPc,
                      tagA & maskA, tagB & maskB};

  // XOR fold of the key into a set index
  always_comb begin
    padded = '0;
    padded[KEY_W-1:0] = lookupKey;
    setIdx = '0;
    for (int c = 0; c < CHUNKS; c++) setIdx ^= padded[c*IDX_W +: IDX_W];
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign wayMatch[w] = validMem[setIdx][w] && (keyMem[setIdx][w] == lookupKey);
  end
  assign hitFound = |wayMatch;

  always_comb begin
    hitTrap = 1'b0; hitVec = '0; hitRes = '0; hitPc = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (wayMatch[w]) begin
        hitTrap = trapMem[setIdx][w];
        hitVec  = vecMem[setIdx][w];
        hitRes  = resMem[setIdx][w];
        hitPc   = pcMem[setIdx][w];
      end
    end
  end

  // valid bits and replacement pointers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validMem[s] <= '0;
        rrPtr[s] <= '0;
      end
    end else if (strobes.flushAll) begin
      for (int s = 0; s < SETS; s++) validMem[s] <= '0;
    end else if (strobes.install) begin
      validMem[pendIdx][rrPtr[pendIdx]] <= 1'b1;
      rrPtr[pendIdx] <= rrPtr[pendIdx] + WAY_W'(1);
    end
  end

  // entry payload, no reset needed
  always_ff @(posedge clk) begin
    if (strobes.install) begin
      keyMem[pendIdx][rrPtr[pendIdx]]  <= pendKey;
      trapMem[pendIdx][rrPtr[pendIdx]] <= refillTrap;
      vecMem[pendIdx][rrPtr[pendIdx]]  <= refillVec;
      resMem[pendIdx][rrPtr[pendIdx]]  <= refillResTag;
      pcMem[pendIdx][rrPtr[pendIdx]]   <= refillPcTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendKey <= '0;
      pendIdx <= '0;
      outValid <= 1'b0;
      outTrap <= 1'b0;
      outVec <= '0;
      outRes <= '0;
      outPc <= '0;
    end else begin
      outValid <= strobes.loadHit || strobes.loadRefill;
      if (strobes.capture) begin
        pendKey <= lookupKey;
        pendIdx <= setIdx;
      end
      if (strobes.loadHit) begin
        outTrap <= hitTrap; outVec <= hitVec; outRes <= hitRes; outPc <= hitPc;
      end else if (strobes.loadRefill) begin
        outTrap <= refillTrap; outVec <= refillVec;
        outRes <= refillResTag; outPc <= refillPcTag;
      end
    end
  end
endmodule

// File: rtl/tag_rule_cache.sv
module tag_rule_cache
  import tag_rule_cache_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int OPC_W  = 8,
  parameter int PRIN_W = 8,
  parameter int VEC_W  = 5,
  parameter int WAYS   = 4,
  parameter int SETS   = 64,
  localparam int KEY_W = 3 * TAG_W + OPC_W + PRIN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              lookupValid,
  input  logic [TAG_W-1:0]  tagA,
  input  logic [TAG_W-1:0]  tagB,
  input  logic [TAG_W-1:0]  pcTag,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [PRIN_W-1:0] principal,
  input  logic [TAG_W-1:0]  maskA,
  input  logic [TAG_W-1:0]  maskB,
  input  logic [TAG_W-1:0]  maskPc,
  input  logic [OPC_W-1:0]  maskOpc,
  output logic              lookupStall,
  output logic              hitValid,
  output logic              trap,
  output logic [VEC_W-1:0]  trapVec,
  output logic [TAG_W-1:0]  resTag,
  output logic [TAG_W-1:0]  newPcTag,
  output logic              refillReq,
  output logic [KEY_W-1:0]  refillKey,
  input  logic              refillValid,
  input  logic              refillTrap,
  input  logic [VEC_W-1:0]  refillVec,
  input  logic [TAG_W-1:0]  refillResTag,
  input  logic [TAG_W-1:0]  refillPcTag
);
  ctlStrobes_t strobes;
  logic hitFound;

  tag_rule_cache_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .hitFound(hitFound),
    .flush(flush), .refillValid(refillValid), .strobes(strobes),
    .lookupStall(lookupStall), .refillReq(refillReq)
  );

  tag_rule_cache_dp #(
    .TAG_W(TAG_W), .OPC_W(OPC_W), .PRIN_W(PRIN_W), .VEC_W(VEC_W),
    .WAYS(WAYS), .SETS(SETS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .tagA(tagA), .tagB(tagB), .pcTag(pcTag), .opcode(opcode),
    .principal(principal), .maskA(maskA), .maskB(maskB),
    .maskPc(maskPc), .maskOpc(maskOpc),
    .refillTrap(refillTrap), .refillVec(refillVec),
    .refillResTag(refillResTag), .refillPcTag(refillPcTag),
    .hitFound(hitFound), .outValid(hitValid), .outTrap(trap),
    .outVec(trapVec), .outRes(resTag), .outPc(newPcTag), .pendKey(refillKey)
  );
endmodule

// File: rtl/tag_rule_cache_chk.sv
module tag_rule_cache_chk #(
  parameter int KEY_W = 40
) (
  input logic             clk,
  input logic             rstN,
  input logic             lookupValid,
  input logic             refillValid,
  input logic             lookupStall,
  input logic             hitValid,
  input logic             refillReq,
  input logic [KEY_W-1:0] refillKey
);
  assert_req_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    refillReq |=> !refillReq);
  assert_req_in_stall_R5: assert property (@(posedge clk) disable iff (!rstN)
    refillReq |-> lookupStall);
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lookupStall && !refillValid) |=> lookupStall);
  assert_key_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lookupStall && $past(lookupStall)) |-> $stable(refillKey));
  assert_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lookupStall && refillValid) |=> (hitValid && !lookupStall));
  assert_result_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> ($past(lookupValid) || $past(refillValid)));
  assert_stray_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (lookupStall && !refillValid) |=> !hitValid);
endmodule

bind tag_rule_cache tag_rule_cache_chk #(.KEY_W(KEY_W)) chk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .refillValid(refillValid),
  .lookupStall(lookupStall), .hitValid(hitValid), .refillReq(refillReq),
  .refillKey(refillKey)
);

// File: tb/tag_rule_cache_test.sv
module tag_rule_cache_test;
  logic clk = 1'b0, rstN = 1'b0, flush = 1'b0, lookupValid = 1'b0;
  logic [7:0] tagA = '0, tagB = '0, pcTag = '0, opcode = '0, principal = '0;
  logic [7:0] maskA = 8'hFF, maskB = 8'hFF, maskPc = 8'hFF, maskOpc = 8'hFF;
  logic lookupStall, hitValid, trap, refillReq;
  logic [4:0] trapVec;
  logic [7:0] resTag, newPcTag;
  logic [39:0] refillKey;
  logic refillValid = 1'b0, refillTrap = 1'b0;
  logic [4:0] refillVec = '0;
  logic [7:0] refillResTag = '0, refillPcTag = '0;

  int checks = 0, fails = 0;

  typedef struct {
    logic       trap;
    logic [4:0] vec;
    logic [7:0] res;
    logic [7:0] pc;
    string      req;
  } expItem_t;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  tag_rule_cache uut (.*);

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench policy table: a pure function of the key
  function automatic expItem_t policy(input logic [39:0] k, input string req);
    expItem_t e;
    e.trap = ^k;
    e.vec  = k[4:0] ^ k[36:32];
    e.res  = k[7:0] ^ k[15:8] ^ k[39:32];
    e.pc   = k[23:16] + 8'd1;
    e.req  = req;
    return e;
  endfunction

  function automatic logic [39:0] mkKey(input logic [7:0] a, b, pc, op, pr);
    return {pr, op & maskOpc, pc & maskPc, a & maskA, b & maskB};
  endfunction

  // monitor: compare every result against the scoreboard
  always @(negedge clk) begin
    if (rstN && hitValid) begin
      if (expQ.size() == 0) check(1'b0, "R10 unexpected result", 64'd1, 64'd0);
      else begin
        expItem_t e;
        e = expQ.pop_front();
        check({trap, trapVec, resTag, newPcTag} == {e.trap, e.vec, e.res, e.pc},
              e.req, {trap, trapVec, resTag, newPcTag}, {e.trap, e.vec, e.res, e.pc});
      end
    end
  end

  task automatic lookup(input logic [7:0] a, b, pc, op, pr, input bit expMiss,
                        input bit withFlush, input bit stray, input string req);
    logic [39:0] key;
    expItem_t e;
    key = mkKey(a, b, pc, op, pr);
    e = policy(key, req);
    @(negedge clk);
    tagA = a; tagB = b; pcTag = pc; opcode = op; principal = pr;
    lookupValid = 1'b1; flush = withFlush;
    expQ.push_back(e);
    @(negedge clk);
    lookupValid = 1'b0; flush = 1'b0;
    if (expMiss) begin
      check(lookupStall && refillReq && !hitValid, {req, " R5 miss handshake"},
            {lookupStall, refillReq, hitValid}, 3'b110);
      check(refillKey == key, {req, " R5 refill key"}, refillKey, key);
      for (int i = 0; i < 2; i++) begin
        if (stray) begin tagA = a ^ 8'hCC; lookupValid = 1'b1; end
        @(negedge clk);
        lookupValid = 1'b0;
        check(lookupStall && !refillReq && !hitValid, {req, " R6 stall held"},
              {lookupStall, refillReq, hitValid}, 3'b100);
      end
      refillValid = 1'b1; refillTrap = e.trap; refillVec = e.vec;
      refillResTag = e.res; refillPcTag = e.pc;
      @(negedge clk);
      refillValid = 1'b0;
      check(hitValid && !lookupStall, {req, " R6 release"},
            {hitValid, lookupStall}, 2'b10);
    end else begin
      check(hitValid && !lookupStall && !refillReq, {req, " R4 hit next cycle"},
            {hitValid, lookupStall, refillReq}, 3'b100);
    end
  endtask

  task automatic pulseFlush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "R6 watchdog", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!lookupStall && !hitValid && !refillReq, "R1 reset outputs",
          {lookupStall, hitValid, refillReq}, 3'b000);
    lookup(8'h11, 8'h22, 8'h33, 8'h44, 8'h01, 1, 0, 0, "R1 first lookup misses");
    lookup(8'h11, 8'h22, 8'h33, 8'h44, 8'h01, 0, 0, 0, "R7 refilled entry hits");
    lookup(8'h11, 8'h22, 8'h33, 8'h44, 8'h02, 1, 0, 0, "R3 other principal misses");
    lookup(8'h11, 8'h22, 8'h33, 8'h44, 8'h01, 0, 0, 0, "R3 first principal still hits");
    lookup(8'h23, 8'h47, 8'h3C, 8'h81, 8'h01, 1, 0, 0, "R4 trap pattern refill");
    lookup(8'h23, 8'h47, 8'h3C, 8'h81, 8'h01, 0, 0, 0, "R4 trap pattern hit");
    // R2: masked-off bits of tagA do not matter
    maskA = 8'h0F;
    lookup(8'h35, 8'h10, 8'h20, 8'h30, 8'h07, 1, 0, 0, "R2 masked key refill");
    lookup(8'h75, 8'h10, 8'h20, 8'h30, 8'h07, 0, 0, 0, "R2 masked bits ignored");
    maskA = 8'hFF;
    // R10: lookups during a stall are ignored
    lookup(8'h5A, 8'h66, 8'h77, 8'h88, 8'h03, 1, 0, 1, "R10 stall with stray lookups");
    lookup(8'h5A ^ 8'hCC, 8'h66, 8'h77, 8'h88, 8'h03, 1, 0, 0, "R10 stray key not installed");
    // R9: tagA=k<<4, tagB=k keeps the folded index constant
    for (int k = 1; k <= 5; k++)
      lookup(8'(k << 4), 8'(k), 8'h00, 8'h00, 8'h05, 1, 0, 0, "R9 fill one set");
    lookup(8'h10, 8'h01, 8'h00, 8'h00, 8'h05, 1, 0, 0, "R9 oldest evicted");
    lookup(8'h30, 8'h03, 8'h00, 8'h00, 8'h05, 0, 0, 0, "R9 third key kept");
    lookup(8'h20, 8'h02, 8'h00, 8'h00, 8'h05, 1, 0, 0, "R9 second key evicted");
    lookup(8'h40, 8'h04, 8'h00, 8'h00, 8'h05, 0, 0, 0, "R9 fourth key kept");
    // R8: flush
    lookup(8'h11, 8'h22, 8'h33, 8'h44, 8'h01, 1, 1, 0, "R8 lookup with flush misses");
    pulseFlush();
    lookup(8'h11, 8'h22, 8'h33, 8'h44, 8'h01, 1, 0, 0, "R8 entry gone after flush");
    lookup(8'h40, 8'h04, 8'h00, 8'h00, 8'h05, 1, 0, 0, "R8 other set also flushed");
    lookup(8'h11, 8'h22, 8'h33, 8'h44, 8'h01, 0, 0, 0, "R7 hit after refill");
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R4 all results delivered", expQ.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule